// File: doc/BRIEF.md
# Multi-Level Power State Controller

This block manages the supply of a bank of processing engines inside a crypto accelerator. For every engine it keeps a requested power level and drives that engine's two-bit supply-level select, its power-gate enable and its output isolation. There are three active supply levels and one gated sleep level. The block orders each change so that the engine is never left in an unsafe electrical condition, and it reports for each engine whether a change is still in progress and whether the engine can be used.

Software writes one engine's requested level at a time, as an index plus a two-bit level code. An allocation mask states which engines the schedule uses. An engine outside the mask is driven to sleep whatever was written for it. Each engine reports whether a task is running and pulses a completion line when the task ends, and the controller never cuts power under a running task. A move between two active levels waits a short settling count. A wake from sleep waits a much longer count, with isolation still applied. Entering sleep first isolates the engine for one cycle and then opens the gate.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset every engine shows level code 00, gate enable low, isolation high, busy low and ready low.
- R2: Level codes are 00 sleep, 01 lowest active, 10 middle active and 11 highest active. Engine e owns bits [2e+1:2e] of the level bus. The level code reads 00 whenever the gate enable is low.
- R3: A request for an active level on a sleeping engine raises the gate enable while isolation stays high. The engine is then busy for exactly PG_WAKE cycles, after which isolation falls and ready rises.
- R4: A change between two different active levels updates the level code and keeps the engine busy for exactly DVS_WAIT cycles. The gate enable stays high and isolation stays low for the whole change.
- R5: A request for the level the engine already holds causes no busy cycle, and ready stays high.
- R6: A sleep request made while the engine's run input is high leaves the gate enable high and busy high until a completion pulse arrives.
- R7: Entering sleep raises isolation for one busy cycle while the gate is still on. The gate enable falls on the next cycle, with the level code at 00.
- R8: If an active level is requested again while a sleep request is waiting for completion, the sleep is abandoned. The engine moves to the new level without the gate ever dropping.
- R9: An engine whose allocation bit is low is driven to sleep and stays there whatever level is written for it. When its bit goes high, it wakes to the written level.
- R10: A write whose index is not below NUM_ENG changes no engine's level, gate, isolation or busy output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Request write strobe |
| wr_idx | input | IDX_W | Engine index for the write |
| wr_lvl | input | 2 | Requested level code |
| alloc_mask | input | NUM_ENG | High bit marks an engine the schedule uses |
| eng_run | input | NUM_ENG | High while an engine is executing a task |
| eng_done | input | NUM_ENG | One-cycle completion pulse per engine |
| lvl_sel | output | 2*NUM_ENG | Supply-level select per engine |
| gate_en | output | NUM_ENG | Power-gate enable per engine (high = powered) |
| iso_en | output | NUM_ENG | Output isolation per engine |
| busy | output | NUM_ENG | Transition in progress |
| ready | output | NUM_ENG | Engine powered, settled and unisolated |

## Verification
The bench builds the block with NUM_ENG=3, DVS_WAIT=4 and PG_WAKE=10. With three engines and a two-bit index, index 3 exists on the bus but names no engine, so the ignored-write case in R10 can be tested. The short and distinct wait counts let exact busy-cycle counts separate a settle from a wake inside short windows. Completion is driven by hand, so the held-sleep and abandoned-sleep orderings fall at chosen cycles.

// File: rtl/pwr_ctrl_pkg.sv
// Shared level codes and sequencer phases for the power state controller.
// Assumes a two-bit level code whose zero value means power-gated.
package pwr_ctrl_pkg;
    typedef enum logic [1:0] {
        LV_SLEEP = 2'b00,
        LV_ULTRA = 2'b01,
        LV_LOW   = 2'b10,
        LV_FULL  = 2'b11
    } lvl_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETTLE,
        PH_HOLD,
        PH_ISO,
        PH_WAKE
    } phase_e;
endpackage

// File: rtl/pwr_req_bank.sv
// Request register bank: holds the last level written for each engine and
// presents the effective target, which is forced to sleep for engines that
// are not allocated. Assumes writes name one engine per cycle.
module pwr_req_bank #(
    parameter int NUM_ENG = 4,
    parameter int IDX_W   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [1:0]           wr_lvl,
    input  logic [NUM_ENG-1:0]   alloc_mask,
    output logic [2*NUM_ENG-1:0] eff_req
);
    import pwr_ctrl_pkg::*;

    localparam int REQ_W = 2 * NUM_ENG;

    logic [REQ_W-1:0] req_q;

    for (genvar g = 0; g < NUM_ENG; g++) begin : g_req
        logic hit;
        assign hit = wr_en && (wr_idx == IDX_W'(g));

        // Capture the written level for this engine.
        always_ff @(posedge clk) begin
            if (!rst_n)
                req_q[2*g +: 2] <= LV_SLEEP;
            else if (hit)
                req_q[2*g +: 2] <= wr_lvl;
        end

        // Unallocated engines are always targeted at sleep.
        assign eff_req[2*g +: 2] = alloc_mask[g] ? req_q[2*g +: 2] : LV_SLEEP;
    end

    // Writes naming no engine must leave every stored request untouched.
    assert_range_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ({1'b0, wr_idx} >= (IDX_W+1)'(NUM_ENG))) |=> $stable(req_q));
endmodule

// File: rtl/pwr_eng_seq.sv
// Per-engine transition sequencer. Walks one engine from its present level
// to the effective target: settles active-to-active changes, wakes from
// sleep with isolation held, waits for task completion before sleeping and
// isolates for one cycle before opening the gate. Assumes DVS_WAIT >= 1
// and PG_WAKE >= 1; the target input may change at any cycle.
module pwr_eng_seq #(
    parameter int DVS_WAIT = 8,
    parameter int PG_WAKE  = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] want,
    input  logic       run,
    input  logic       done,
    output logic [1:0] lvl,
    output logic       gate,
    output logic       iso,
    output logic       busy,
    output logic       ready
);
    import pwr_ctrl_pkg::*;

    localparam int MAX_WAIT = (PG_WAKE > DVS_WAIT) ? PG_WAKE : DVS_WAIT;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);

    phase_e           phase_q;
    logic [1:0]       lvl_q;
    logic             gate_q;
    logic             iso_q;
    logic [CNT_W-1:0] cnt_q;

    // Phase machine with the wait counter and the three control outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            lvl_q   <= LV_SLEEP;
            gate_q  <= 1'b0;
            iso_q   <= 1'b1;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (want != lvl_q) begin
                        if (want == LV_SLEEP) begin
                            if (run && !done) begin
                                phase_q <= PH_HOLD;
                            end else begin
                                phase_q <= PH_ISO;
                                iso_q   <= 1'b1;
                            end
                        end else if (!gate_q) begin
                            gate_q  <= 1'b1;
                            lvl_q   <= want;
                            cnt_q   <= CNT_W'(PG_WAKE);
                            phase_q <= PH_WAKE;
                        end else begin
                            lvl_q   <= want;
                            cnt_q   <= CNT_W'(DVS_WAIT);
                            phase_q <= PH_SETTLE;
                        end
                    end
                end
                PH_SETTLE: begin
                    if (cnt_q == CNT_W'(1))
                        phase_q <= PH_IDLE;
                    else
                        cnt_q <= cnt_q - CNT_W'(1);
                end
                PH_HOLD: begin
                    if (want != LV_SLEEP) begin
                        phase_q <= PH_IDLE;
                    end else if (done) begin
                        phase_q <= PH_ISO;
                        iso_q   <= 1'b1;
                    end
                end
                PH_ISO: begin
                    gate_q  <= 1'b0;
                    lvl_q   <= LV_SLEEP;
                    phase_q <= PH_IDLE;
                end
                PH_WAKE: begin
                    if (cnt_q == CNT_W'(1)) begin
                        iso_q   <= 1'b0;
                        phase_q <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Status derived from the phase and the gate state.
    assign busy  = (phase_q != PH_IDLE);
    assign ready = (phase_q == PH_IDLE) && gate_q && !iso_q;
    assign lvl   = lvl_q;
    assign gate  = gate_q;
    assign iso   = iso_q;

    assert_iso_before_gateoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_q) |-> $past(iso_q));
    assert_wake_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_q) |-> iso_q);
    assert_sleep_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_q |-> (lvl_q == LV_SLEEP));
    assert_settle_powered_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SETTLE) |-> (gate_q && !iso_q));
    assert_hold_keeps_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HOLD) |=> gate_q);
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_WAIT));
endmodule

// File: rtl/pwr_state_ctrl.sv
// Top of the multi-level power state controller: a request bank feeding one
// transition sequencer per engine. Assumes the level generators and power
// switches act on the outputs directly and that each engine's run/done
// lines are synchronous to clk.
module pwr_state_ctrl #(
    parameter int NUM_ENG  = 4,
    parameter int DVS_WAIT = 8,
    parameter int PG_WAKE  = 64,
    localparam int IDX_W   = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [1:0]           wr_lvl,
    input  logic [NUM_ENG-1:0]   alloc_mask,
    input  logic [NUM_ENG-1:0]   eng_run,
    input  logic [NUM_ENG-1:0]   eng_done,
    output logic [2*NUM_ENG-1:0] lvl_sel,
    output logic [NUM_ENG-1:0]   gate_en,
    output logic [NUM_ENG-1:0]   iso_en,
    output logic [NUM_ENG-1:0]   busy,
    output logic [NUM_ENG-1:0]   ready
);
    logic [2*NUM_ENG-1:0] eff_req;

    pwr_req_bank #(
        .NUM_ENG (NUM_ENG),
        .IDX_W   (IDX_W)
    ) req_bank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_lvl     (wr_lvl),
        .alloc_mask (alloc_mask),
        .eff_req    (eff_req)
    );

    for (genvar g = 0; g < NUM_ENG; g++) begin : g_eng
        pwr_eng_seq #(
            .DVS_WAIT (DVS_WAIT),
            .PG_WAKE  (PG_WAKE)
        ) seq_i (
            .clk   (clk),
            .rst_n (rst_n),
            .want  (eff_req[2*g +: 2]),
            .run   (eng_run[g]),
            .done  (eng_done[g]),
            .lvl   (lvl_sel[2*g +: 2]),
            .gate  (gate_en[g]),
            .iso   (iso_en[g]),
            .busy  (busy[g]),
            .ready (ready[g])
        );
    end

    assert_ready_not_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready & busy) == '0);
endmodule

// File: tb/pwr_state_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_state_ctrl_tb_top;
    localparam int ENG = 3;
    localparam int DW  = 4;
    localparam int PW  = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [1:0]     wr_idx = '0;
    logic [1:0]     wr_lvl = '0;
    logic [ENG-1:0] alloc_mask = '0;
    logic [ENG-1:0] eng_run = '0;
    logic [ENG-1:0] eng_done = '0;
    logic [2*ENG-1:0] lvl_sel;
    logic [ENG-1:0] gate_en, iso_en, busy, ready;

    int nvec = 0;
    int nfail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pwr_state_ctrl #(.NUM_ENG(ENG), .DVS_WAIT(DW), .PG_WAKE(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_lvl(wr_lvl),
        .alloc_mask(alloc_mask), .eng_run(eng_run), .eng_done(eng_done),
        .lvl_sel(lvl_sel), .gate_en(gate_en), .iso_en(iso_en), .busy(busy), .ready(ready)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(int e, logic [1:0] l);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = e[1:0]; wr_lvl = l;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic observe(int e, int win, output int nb, output bit iso_on, output bit dropped);
        nb = 0; iso_on = 1'b0; dropped = 1'b0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk); #1;
            if (busy[e]) nb++;
            if (iso_en[e] && gate_en[e]) iso_on = 1'b1;
            if (!gate_en[e]) dropped = 1'b1;
        end
    endtask

    task automatic t_reset;
        @(negedge clk); #1;
        chk(lvl_sel == '0, "R1 level", int'(lvl_sel), 0);
        chk(gate_en == '0, "R1 gate", int'(gate_en), 0);
        chk(iso_en == '1, "R1 iso", int'(iso_en), 7);
        chk(busy == '0 && ready == '0, "R1 busy/ready", int'({busy, ready}), 0);
    endtask

    task automatic t_wake;
        int nb; bit io, dr;
        wr(0, 2'b11);
        observe(0, 30, nb, io, dr);
        chk(nb == PW, "R3 wake busy cycles", nb, PW);
        chk(io, "R3 isolated while waking", int'(io), 1);
        chk(lvl_sel[1:0] == 2'b11, "R2 full code", int'(lvl_sel[1:0]), 3);
        chk(gate_en[0] && !iso_en[0] && ready[0], "R3 ready after wake",
            int'({gate_en[0], iso_en[0], ready[0]}), 5);
        chk(lvl_sel[3:2] == 2'b00 && !gate_en[1], "R2 idle engine code", int'(lvl_sel[3:2]), 0);
    endtask

    task automatic t_dvs;
        int nb; bit io, dr;
        wr(0, 2'b01);
        observe(0, 20, nb, io, dr);
        chk(nb == DW, "R4 settle busy cycles", nb, DW);
        chk(!dr && !io, "R4 gate kept", int'({dr, io}), 0);
        chk(lvl_sel[1:0] == 2'b01 && ready[0], "R4 new level", int'(lvl_sel[1:0]), 1);
    endtask

    task automatic t_same;
        int nb; bit io, dr;
        wr(0, 2'b01);
        observe(0, 10, nb, io, dr);
        chk(nb == 0, "R5 no busy", nb, 0);
        chk(ready[0] && lvl_sel[1:0] == 2'b01, "R5 ready kept", int'(ready[0]), 1);
    endtask

    task automatic t_hold;
        int nb; bit io, dr;
        eng_run[0] = 1'b1;
        wr(0, 2'b00);
        observe(0, 20, nb, io, dr);
        chk(!dr && gate_en[0], "R6 gate held while running", int'(gate_en[0]), 1);
        chk(nb == 20, "R6 busy while held", nb, 20);
        @(negedge clk);
        eng_done[0] = 1'b1; eng_run[0] = 1'b0;
        @(negedge clk);
        eng_done[0] = 1'b0;
        #1;
        chk(iso_en[0] && gate_en[0] && busy[0], "R7 isolate before gate-off",
            int'({iso_en[0], gate_en[0], busy[0]}), 7);
        observe(0, 5, nb, io, dr);
        chk(!gate_en[0] && lvl_sel[1:0] == 2'b00 && nb == 0, "R7 gated off",
            int'({gate_en[0], lvl_sel[1:0]}), 0);
    endtask

    task automatic t_cancel;
        int nb; bit io, dr;
        wr(0, 2'b01);
        observe(0, 30, nb, io, dr);
        eng_run[0] = 1'b1;
        wr(0, 2'b00);
        observe(0, 5, nb, io, dr);
        chk(nb == 5 && !dr, "R8 sleep waiting", nb, 5);
        wr(0, 2'b10);
        observe(0, 20, nb, io, dr);
        chk(!dr, "R8 gate never dropped", int'(dr), 0);
        chk(lvl_sel[1:0] == 2'b10 && ready[0], "R8 new level", int'(lvl_sel[1:0]), 2);
        eng_run[0] = 1'b0;
    endtask

    task automatic t_alloc;
        int nb; bit io, dr;
        alloc_mask[1] = 1'b0;
        wr(1, 2'b11);
        observe(1, 30, nb, io, dr);
        chk(nb == 0 && !gate_en[1], "R9 unallocated stays asleep", int'(gate_en[1]), 0);
        chk(lvl_sel[3:2] == 2'b00, "R9 unallocated code", int'(lvl_sel[3:2]), 0);
        @(negedge clk);
        alloc_mask[1] = 1'b1;
        observe(1, 30, nb, io, dr);
        chk(nb == PW && lvl_sel[3:2] == 2'b11, "R9 wake on allocate", nb, PW);
        @(negedge clk);
        alloc_mask[1] = 1'b0;
        observe(1, 10, nb, io, dr);
        chk(nb == 1 && !gate_en[1], "R9 forced off", nb, 1);
    endtask

    task automatic t_range;
        logic [2*ENG-1:0] l0;
        logic [ENG-1:0] g0, i0;
        bit anybusy;
        @(negedge clk); #1;
        l0 = lvl_sel; g0 = gate_en; i0 = iso_en;
        wr(3, 2'b11);
        anybusy = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1;
            if (busy != '0) anybusy = 1'b1;
        end
        chk(!anybusy, "R10 no busy", int'(anybusy), 0);
        chk(lvl_sel == l0 && gate_en == g0 && iso_en == i0, "R10 outputs unchanged",
            int'(lvl_sel), int'(l0));
    endtask

    initial begin
        alloc_mask = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_wake();
        t_dvs();
        t_same();
        t_hold();
        t_cancel();
        t_alloc();
        t_range();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            finished = 1'b1;
            nvec++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule